// File: doc/BRIEF.md
# Half-Duplex Back-Pressure Jammer

This block applies flow control to a half-duplex Ethernet MAC by deliberately colliding with incoming frames. It compares the receive buffer's fill level against a programmable upper and lower bound. Crossing the upper bound, or a request from software, marks back pressure as pending. While back pressure is pending, every frame that begins on the receive side is answered with a 32-bit jam word. The jam word is sent on the 4-bit transmit path, least significant nibble first, with transmit enable held high.

After each jam the block waits for a programmable hold-off interval. During that interval the remote station backs off and prepares its retry. If the demand for back pressure lasts through the whole interval, the retried frame is jammed again. If the fill level drops below the lower bound during the interval, and software is not asking, the pending state ends and the retried frame is let through. Because the set and release points differ, the block does not jam and release every other frame while the buffer hovers near one level.

Top module: `bp_jam_ctrl`

## Requirements
- R1: While `half_duplex` is 0 the block never leaves idle: `pending` stays 0 and `tx_en` stays 0, whatever the level, request and frame inputs do.
- R2: With `half_duplex` at 1, a `sw_req` of 1 sampled in idle makes `pending` read 1 after the next rising clock edge.
- R3: The hardware demand is set when `fifo_level` is strictly greater than `thr_high` and cleared when it is strictly less than `thr_low`; for levels in between it keeps its previous value. A new level reaches `pending` after two clock edges.
- R4: A `rx_frame_start` pulse while pending and waiting starts a jam on the next edge. `tx_en` is 1 for exactly 8 consecutive cycles, and `tx_data` carries nibble i of 0x55555555 (bits 4i+3..4i, so always 4'h5) in beat i. Outside a jam, `tx_data` is 0.
- R5: After the last jam beat, `in_holdoff` is 1 for exactly `holdoff_cycles` cycles. A value of 0 counts as 1. `tx_en` is 0 throughout.
- R6: If the demand (software or hardware) stays present through the whole hold-off, `pending` remains 1 afterwards, and the next frame start is jammed again.
- R7: If the demand is absent on any cycle of the hold-off, `pending` is 0 when the hold-off ends, and the next frame start is accepted.
- R8: Frame starts that arrive during a jam or a hold-off are ignored: the jam length and the hold-off length do not change.
- R9: Clearing `sw_req` while waiting, with no hardware demand, returns `pending` to 0 after the next edge. Clearing it during a jam lets the full 8-beat jam complete.
- R10: `frame_accept` equals `rx_frame_start` in the same cycle when the block is idle, or when it is waiting with no demand. It is 0 whenever that frame start triggers a jam, and 0 during a jam or hold-off.
- R11: After reset `pending`, `tx_en`, `tx_data`, `in_holdoff` and `frame_accept` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_duplex | input | 1 | 1 when the link runs half duplex |
| sw_req | input | 1 | Software request for back pressure |
| fifo_level | input | LVL_W | Current receive buffer fill in bytes |
| thr_high | input | LVL_W | Level above which demand is set |
| thr_low | input | LVL_W | Level below which demand is cleared |
| holdoff_cycles | input | CNT_W | Hold-off length in clock cycles after each jam |
| rx_frame_start | input | 1 | One-cycle pulse at the start of an incoming frame |
| tx_data | output | TX_W | Jam nibble on the transmit path |
| tx_en | output | 1 | Transmit enable, high during a jam |
| pending | output | 1 | Back pressure pending |
| in_holdoff | output | 1 | Hold-off interval running |
| frame_accept | output | 1 | The current frame start is let through |

## Verification
The bench sweeps the fill level up and down through every value of a 6-bit range, checking the band between the bounds. A design using a single threshold, or one compared with the wrong strictness, would switch `pending` at the wrong level. Hold-off lengths 0 to 6 are each measured. An off-by-one counter, or a zero length that hangs or skips the hold-off, shows up there. Stray frame starts are injected in the middle of jams and hold-offs. A design that restarts its serializer or reloads its timer would stretch one of them. Demand is removed inside the hold-off, both by the level and by software. A design that samples the release only at the end, or never, would jam a frame it should accept.

// File: rtl/bp_jam_pkg.sv
package bp_jam_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_JAM  = 2'd2,
    ST_HOLD = 2'd3
  } bp_state_t;

  // Next value of a hysteresis flag: upper crossing wins, lower crossing clears.
  function automatic logic hyst_next(logic cur, logic above_high, logic below_low);
    if (above_high)     return 1'b1;
    else if (below_low) return 1'b0;
    else                return cur;
  endfunction

  // Hold-off length actually run; zero is promoted to one cycle.
  function automatic int unsigned hold_len(int unsigned cycles);
    return (cycles == 0) ? 1 : cycles;
  endfunction

endpackage

// File: rtl/bp_level_hyst.sv
module bp_level_hyst #(
  parameter int LVL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thr_high,
  input  logic [LVL_W-1:0] thr_low,
  output logic             hw_demand
);
  import bp_jam_pkg::*;

  logic above_high;
  logic below_low;
  logic hw_q;

  assign above_high = (level > thr_high);
  assign below_low  = (level < thr_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hw_q <= 1'b0;
    else        hw_q <= hyst_next(hw_q, above_high, below_low);
  end

  assign hw_demand = hw_q;

  AST_HIGH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    above_high |=> hw_demand); // R3
  AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!above_high && !below_low) |=> $stable(hw_demand)); // R3
  AST_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (below_low && !above_high) |=> !hw_demand); // R3

endmodule

// File: rtl/bp_jam_serializer.sv
module bp_jam_serializer #(
  parameter int                TX_W     = 4,
  parameter int                JAM_BITS = 32,
  parameter logic [JAM_BITS-1:0] PATTERN = 32'h5555_5555
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            active,
  output logic [TX_W-1:0] beat_data,
  output logic            last_beat
);
  localparam int BEATS = JAM_BITS / TX_W;
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (!active_q) begin
      if (start) begin
        active_q <= 1'b1;
        idx_q    <= '0;
      end
    end else if (idx_q == LAST_IDX) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign active    = active_q;
  assign last_beat = active_q && (idx_q == LAST_IDX);
  assign beat_data = active_q ? PATTERN[idx_q*TX_W +: TX_W] : '0;

  AST_JAM_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !last_beat) |=> active_q); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> (!active_q || (idx_q == $past(idx_q) + IDX_W'(1)))); // R8

endmodule

// File: rtl/bp_holdoff_timer.sv
module bp_holdoff_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] length,
  output logic             running,
  output logic             expire
);
  import bp_jam_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= CNT_W'(hold_len(32'(length)));
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign running = (cnt_q != '0);
  assign expire  = (cnt_q == CNT_W'(1));

  AST_EXPIRE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !running); // R5
  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> running); // R5

endmodule

// File: rtl/bp_jam_ctrl.sv
module bp_jam_ctrl #(
  parameter int                  LVL_W    = 12,
  parameter int                  CNT_W    = 16,
  parameter int                  TX_W     = 4,
  parameter int                  JAM_BITS = 32,
  parameter logic [JAM_BITS-1:0] PATTERN  = 32'h5555_5555
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_duplex,
  input  logic             sw_req,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] thr_high,
  input  logic [LVL_W-1:0] thr_low,
  input  logic [CNT_W-1:0] holdoff_cycles,
  input  logic             rx_frame_start,
  output logic [TX_W-1:0]  tx_data,
  output logic             tx_en,
  output logic             pending,
  output logic             in_holdoff,
  output logic             frame_accept
);
  import bp_jam_pkg::*;

  bp_state_t state_q, state_d;
  logic      released_q;
  logic      hw_demand;
  logic      demand;
  logic      jam_start;
  logic      jam_active;
  logic      jam_last;
  logic      hold_running;
  logic      hold_expire;
  logic      drop_now;

  bp_level_hyst #(.LVL_W(LVL_W)) u_hyst (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (fifo_level),
    .thr_high  (thr_high),
    .thr_low   (thr_low),
    .hw_demand (hw_demand)
  );

  assign demand    = sw_req | hw_demand;
  assign drop_now  = !demand || !half_duplex;
  assign jam_start = (state_q == ST_WAIT) && !drop_now && rx_frame_start;

  bp_jam_serializer #(
    .TX_W(TX_W), .JAM_BITS(JAM_BITS), .PATTERN(PATTERN)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (jam_start),
    .active    (jam_active),
    .beat_data (tx_data),
    .last_beat (jam_last)
  );

  bp_holdoff_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (jam_last),
    .length  (holdoff_cycles),
    .running (hold_running),
    .expire  (hold_expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (half_duplex && demand) state_d = ST_WAIT;
      ST_WAIT: begin
        if (drop_now)            state_d = ST_IDLE;
        else if (rx_frame_start) state_d = ST_JAM;
      end
      ST_JAM:  if (jam_last) state_d = ST_HOLD;
      ST_HOLD: if (hold_expire)
                 state_d = (released_q || drop_now) ? ST_IDLE : ST_WAIT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      released_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (jam_last)
        released_q <= 1'b0;
      else if (state_q == ST_HOLD && drop_now)
        released_q <= 1'b1;
    end
  end

  assign tx_en        = jam_active;
  assign pending      = (state_q != ST_IDLE);
  assign in_holdoff   = hold_running;
  assign frame_accept = rx_frame_start && !jam_start &&
                        (state_q == ST_IDLE || state_q == ST_WAIT);

  AST_HALF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_duplex && !pending) |=> !pending); // R1
  AST_SW_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (half_duplex && sw_req && !pending) |=> pending); // R2
  AST_JAM_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    jam_start |=> tx_en); // R4
  AST_TXEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> (pending && !in_holdoff)); // R5
  AST_HOLD_AFTER_JAM: assert property (@(posedge clk) disable iff (!rst_n)
    jam_last |=> (in_holdoff && !tx_en)); // R5
  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    in_holdoff |-> pending); // R6
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en || in_holdoff) |-> !frame_accept); // R10

endmodule

// File: tb/bp_jam_ctrl_bench.sv
module bp_jam_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 6;
  localparam int CNT_W = 4;
  localparam int HI = 40;
  localparam int LO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_duplex = 1'b1;
  logic sw_req = 1'b0;
  logic [LVL_W-1:0] fifo_level = '0;
  logic [LVL_W-1:0] thr_high = LVL_W'(HI);
  logic [LVL_W-1:0] thr_low = LVL_W'(LO);
  logic [CNT_W-1:0] holdoff_cycles = CNT_W'(4);
  logic rx_frame_start = 1'b0;
  logic [3:0] tx_data;
  logic tx_en, pending, in_holdoff, frame_accept;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bp_jam_ctrl #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_bp_jam_ctrl (
    .clk(clk), .rst_n(rst_n), .half_duplex(half_duplex), .sw_req(sw_req),
    .fifo_level(fifo_level), .thr_high(thr_high), .thr_low(thr_low),
    .holdoff_cycles(holdoff_cycles), .rx_frame_start(rx_frame_start),
    .tx_data(tx_data), .tx_en(tx_en), .pending(pending),
    .in_holdoff(in_holdoff), .frame_accept(frame_accept)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_nib(int i);
    return (32'h5555_5555 >> (4 * i)) & 32'hF;
  endfunction

  // Jam one frame from the waiting state.
  // act: 0 nothing, 1 drop sw_req at beat 2, 2 drop level during hold-off.
  task automatic do_jam(int hold, int act);
    int n;
    rx_frame_start = 1'b1;
    #1;
    chk(frame_accept == 1'b0, "R10 jammed frame not accepted", frame_accept, 0);
    step();
    rx_frame_start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk(tx_en == 1'b1, "R4 tx_en during jam", tx_en, 1);
      chk(int'(tx_data) == exp_nib(i), "R4 jam nibble", tx_data, exp_nib(i));
      if (act == 1 && i == 2) sw_req = 1'b0;
      rx_frame_start = (i == 3);
      step();
      rx_frame_start = 1'b0;
    end
    chk(tx_en == 1'b0, "R5 tx_en low after jam", tx_en, 0);
    n = 0;
    while (in_holdoff && n < 40) begin
      chk(tx_en == 1'b0, "R5 tx_en low in hold-off", tx_en, 0);
      if (act == 2 && n == 0) fifo_level = LVL_W'(10);
      rx_frame_start = (n == 1);
      n++;
      step();
      rx_frame_start = 1'b0;
    end
    chk(n == ((hold == 0) ? 1 : hold), "R5/R8 hold-off length", n, (hold == 0) ? 1 : hold);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit hw;
    repeat (3) @(posedge clk);
    #1;
    chk(pending == 0 && tx_en == 0 && tx_data == 0 && in_holdoff == 0 && frame_accept == 0,
        "R11 reset state", {pending, tx_en, in_holdoff, frame_accept}, 0);
    rst_n = 1'b1;
    step();

    // R1: full duplex ignores everything
    half_duplex = 1'b0;
    sw_req = 1'b1;
    for (int l = 0; l < 64; l++) begin
      fifo_level = LVL_W'(l);
      rx_frame_start = (l % 5 == 0);
      step();
      rx_frame_start = 1'b0;
      chk(pending == 0 && tx_en == 0, "R1 no back pressure in full duplex", pending, 0);
    end
    sw_req = 1'b0;
    fifo_level = '0;
    step(); step();
    half_duplex = 1'b1;
    step();
    chk(pending == 0, "R1 idle on return to half duplex", pending, 0);

    // R3: hysteresis sweep up then down
    hw = 0;
    for (int l = 0; l < 64; l++) begin
      fifo_level = LVL_W'(l);
      if (l > HI) hw = 1; else if (l < LO) hw = 0;
      step(); step();
      chk(pending == hw, "R3 rising sweep", pending, hw);
    end
    for (int l = 63; l >= 0; l--) begin
      fifo_level = LVL_W'(l);
      if (l > HI) hw = 1; else if (l < LO) hw = 0;
      step(); step();
      chk(pending == hw, "R3 falling sweep", pending, hw);
    end
    // R3 latency: one edge is not enough
    fifo_level = LVL_W'(HI + 1);
    step();
    chk(pending == 0, "R3 latency first edge", pending, 0);
    step();
    chk(pending == 1, "R3 latency second edge", pending, 1);
    fifo_level = '0;
    step(); step();
    chk(pending == 0, "R3 release below low", pending, 0);

    // R10: idle frame accepted
    rx_frame_start = 1'b1;
    #1;
    chk(frame_accept == 1, "R10 idle frame accepted", frame_accept, 1);
    step();
    rx_frame_start = 1'b0;

    // R2 and R6: software demand, hold-off sweep
    sw_req = 1'b1;
    step();
    chk(pending == 1, "R2 software request pends", pending, 1);
    for (int h = 0; h <= 6; h++) begin
      holdoff_cycles = CNT_W'(h);
      do_jam(h, 0);
      chk(pending == 1, "R6 still pending after hold-off", pending, 1);
    end

    // R9: clear software request while waiting
    sw_req = 1'b0;
    step();
    chk(pending == 0, "R9 clear while waiting", pending, 0);

    // R9/R7: clear software request mid-jam
    sw_req = 1'b1;
    holdoff_cycles = CNT_W'(3);
    step();
    do_jam(3, 1);
    chk(pending == 0, "R7 released after sw drop", pending, 0);
    rx_frame_start = 1'b1;
    #1;
    chk(frame_accept == 1, "R7 next frame accepted", frame_accept, 1);
    step();
    rx_frame_start = 1'b0;

    // R6 via level in band: jam again
    fifo_level = LVL_W'(50);
    step(); step();
    chk(pending == 1, "R3 level pends", pending, 1);
    fifo_level = LVL_W'(30);
    holdoff_cycles = CNT_W'(5);
    do_jam(5, 0);
    chk(pending == 1, "R6 level in band keeps pending", pending, 1);
    // R7 via level: drop below low during hold-off
    holdoff_cycles = CNT_W'(6);
    do_jam(6, 2);
    chk(pending == 0, "R7 released by low level", pending, 0);
    rx_frame_start = 1'b1;
    #1;
    chk(frame_accept == 1 && tx_en == 0, "R7 retried frame accepted", frame_accept, 1);
    step();
    rx_frame_start = 1'b0;
    chk(tx_en == 0, "R7 no jam after release", tx_en, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule